// File: doc/BRIEF.md
# Fixed-Point Adjustable Time Counter

This block keeps a 64-bit system time register that grows by a programmable fixed-point increment on every cycle of its reference clock. Because the step is a fraction of a nanosecond scaled by a power of two, software reads the register and shifts it right to get nanoseconds. Trimming the clock rate by parts per billion is a matter of writing a slightly larger or smaller increment. At the nominal 6.4 ns tick the increment is 0x66666666 with a fraction shift of 28. For ticks ten and a hundred times slower it is 0x40000000 with shift 24 and 0x50000000 with shift 21.

Software reaches the block through a small register port with 32-bit data. The low time half, the high time half and the increment each have their own address. A read of the low half latches the high half into a shadow copy, so that the next high read belongs to the same instant. The read path is a two-state machine:
- RD_LIVE: no capture is pending.
- RD_HELD: a captured high half waits.

The state machine has these transitions:
- capture: RD_LIVE or RD_HELD to RD_HELD, on a low read.
- release: RD_HELD to RD_LIVE, on a high read.
- discard: RD_HELD to RD_LIVE, on a time write.

The running time value is also driven out to neighbouring blocks, for timestamp capture and clock-out comparison. A parameter selects the reduced variant. It has a 24-bit increment field and a fixed period value of 1 at bit 24 of the increment register.

Top module: `systime_core`

## Requirements
- R1: Reset clears the time value and the increment to zero and puts the read path in RD_LIVE.
- R2: In every cycle with no time write, the time value becomes time + increment, modulo 2^64. Carries pass from the low half into the high half.
- R3: The increment register is at address 2. In the full variant it keeps wdata[30:0], and a read returns {1'b0, increment}, so bit 31 written as 1 reads back 0. In the reduced variant it keeps wdata[23:0], and a read returns bits [31:24] = 8'h01 above the 24-bit increment.
- R4: A write to address 0 replaces the low half and keeps the high half. A write to address 1 replaces the high half and keeps the low half. In both cases the time does not advance in that cycle.
- R5: An increment write takes effect from the following cycle. The cycle of the write still adds the old increment, and the accumulated time is not disturbed.
- R6: A read of address 0 returns the live low half in the same cycle and enters RD_HELD (capture). A later read of address 1 returns the high half as it was at that capture and returns to RD_LIVE (release).
- R7: A read of address 1 in RD_LIVE returns the live high half.
- R8: A time write in RD_HELD drops the captured half (discard). A following high read returns the live high half.
- R9: A read of address 3 returns zero, and rdata is zero whenever reg_rd is low.
- R10: time_now always shows the current time register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one increment is added per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; rdata is valid in the same cycle |
| reg_addr | input | 2 | 0 time low, 1 time high, 2 increment, 3 reserved |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| time_now | output | 64 | Current time value for neighbouring blocks |

## Verification
The properties assume that a single register access arrives per cycle, that reg_rd and reg_wr are never both high, and that no high read follows a low read in the same cycle. The stimulus table keeps each entry to one access. The directed tests drive reset only while the bus is idle, which keeps the shadow and advance checks valid in every cycle after reset. Wraparound of the full 64-bit value is reached by writing a high half of all ones rather than by waiting.

// File: rtl/systime_pkg.sv
package systime_pkg;

    localparam int HALF_W = 32;

    typedef enum logic [1:0] {
        ADR_TIME_LO = 2'd0,
        ADR_TIME_HI = 2'd1,
        ADR_INCR    = 2'd2,
        ADR_RSVD    = 2'd3
    } reg_addr_e;

    typedef enum logic {
        RD_LIVE = 1'b0,
        RD_HELD = 1'b1
    } rd_state_e;

endpackage

// File: rtl/systime_incr.sv
module systime_incr #(
    parameter int INC_W   = 31,
    parameter bit REDUCED = 1'b0,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [INC_W-1:0]  wdata,
    output logic [INC_W-1:0]  inc_val,
    output logic [DATA_W-1:0] rd_view
);
    localparam int PAD_W = DATA_W - INC_W;

    logic [INC_W-1:0] inc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     inc_q <= '0;
        else if (wr_en) inc_q <= wdata;
    end

    assign inc_val = inc_q;

    generate
        if (REDUCED) begin : g_reduced
            // period field fixed at 1, directly above the increment
            assign rd_view = {{(PAD_W-1){1'b0}}, 1'b1, inc_q};
        end else begin : g_full
            assign rd_view = {{PAD_W{1'b0}}, inc_q};
        end
    endgenerate
endmodule

// File: rtl/systime_acc.sv
module systime_acc #(
    parameter int TIME_W = 64,
    parameter int INC_W  = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [TIME_W/2-1:0] wdata,
    input  logic [INC_W-1:0]  inc_val,
    output logic [TIME_W-1:0] time_q
);
    localparam int HALF = TIME_W / 2;

    logic [TIME_W-1:0] time_d;

    always_comb begin
        if (wr_lo)      time_d = {time_q[TIME_W-1:HALF], wdata};
        else if (wr_hi) time_d = {wdata, time_q[HALF-1:0]};
        else            time_d = time_q + {{(TIME_W-INC_W){1'b0}}, inc_val};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) time_q <= '0;
        else        time_q <= time_d;
    end
endmodule

// File: rtl/systime_rdsel.sv
module systime_rdsel
    import systime_pkg::*;
#(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              time_wr,
    input  logic [1:0]        addr,
    input  logic [TIME_W-1:0] time_q,
    input  logic [HALF_W-1:0] incr_view,
    output logic [HALF_W-1:0] rdata
);
    localparam int HALF = TIME_W / 2;

    rd_state_e         state_q, state_d;
    logic [HALF-1:0]   shadow_q;
    reg_addr_e         a;

    assign a = reg_addr_e'(addr);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= RD_LIVE;
            shadow_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_en && a == ADR_TIME_LO) shadow_q <= time_q[TIME_W-1:HALF];
        end
    end

    // transitions: capture, release, discard
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_LIVE: begin
                if (rd_en && a == ADR_TIME_LO) state_d = RD_HELD;
            end
            RD_HELD: begin
                if (rd_en && a == ADR_TIME_LO)      state_d = RD_HELD;
                else if (rd_en && a == ADR_TIME_HI) state_d = RD_LIVE;
                else if (time_wr)                   state_d = RD_LIVE;
            end
            default: state_d = RD_LIVE;
        endcase
    end

    // outputs
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (a)
                ADR_TIME_LO: rdata = time_q[HALF-1:0];
                ADR_TIME_HI: rdata = (state_q == RD_HELD) ? shadow_q
                                                          : time_q[TIME_W-1:HALF];
                ADR_INCR:    rdata = incr_view;
                ADR_RSVD:    rdata = '0;
                default:     rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/systime_core.sv
module systime_core
    import systime_pkg::*;
#(
    parameter bit REDUCED = 1'b0,
    parameter int TIME_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [63:0]       time_now
);
    localparam int INC_W = REDUCED ? 24 : 31;

    logic              wr_lo, wr_hi, wr_inc;
    logic [INC_W-1:0]  inc_val;
    logic [31:0]       incr_view;
    logic [TIME_W-1:0] time_q;

    assign wr_lo  = reg_wr && (reg_addr == ADR_TIME_LO);
    assign wr_hi  = reg_wr && (reg_addr == ADR_TIME_HI);
    assign wr_inc = reg_wr && (reg_addr == ADR_INCR);

    systime_incr #(.INC_W(INC_W), .REDUCED(REDUCED), .DATA_W(32)) u_incr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_inc),
        .wdata   (reg_wdata[INC_W-1:0]),
        .inc_val (inc_val),
        .rd_view (incr_view)
    );

    systime_acc #(.TIME_W(TIME_W), .INC_W(INC_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wdata   (reg_wdata),
        .inc_val (inc_val),
        .time_q  (time_q)
    );

    systime_rdsel #(.TIME_W(TIME_W)) u_rdsel (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (reg_rd),
        .time_wr   (wr_lo || wr_hi),
        .addr      (reg_addr),
        .time_q    (time_q),
        .incr_view (incr_view),
        .rdata     (reg_rdata)
    );

    assign time_now = time_q;
endmodule

// File: rtl/systime_core_chk.sv
module systime_core_chk #(
    parameter int INC_W   = 31,
    parameter bit REDUCED = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [1:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic [31:0]      reg_rdata,
    input logic [63:0]      time_now,
    input logic [INC_W-1:0] inc_val
);
    logic time_wr;
    assign time_wr = reg_wr && (reg_addr == 2'd0 || reg_addr == 2'd1);

    // R2
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !time_wr |=> time_now == $past(time_now) + {{(64-INC_W){1'b0}}, $past(inc_val)});

    // R4
    wr_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0) |=>
            (time_now[31:0] == $past(reg_wdata) && time_now[63:32] == $past(time_now[63:32])));

    // R4
    wr_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1) |=>
            (time_now[63:32] == $past(reg_wdata) && time_now[31:0] == $past(time_now[31:0])));

    // R6
    pair_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd1 && $past(reg_rd && reg_addr == 2'd0 && !time_wr))
            |-> reg_rdata == $past(time_now[63:32]));

    // R3
    incr_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd2) |->
            (REDUCED ? (reg_rdata[31:24] == 8'h01) : (reg_rdata[31] == 1'b0)));

    // R9
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rd || reg_addr == 2'd3) |-> reg_rdata == 32'd0);
endmodule

bind systime_core systime_core_chk #(.INC_W(INC_W), .REDUCED(REDUCED)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .time_now  (time_now),
    .inc_val   (inc_val)
);

// File: tb/systime_core_tb.sv
module systime_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] rdata_f, rdata_r;
    logic [63:0] time_f, time_r;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    systime_core #(.REDUCED(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata_f), .time_now(time_f));

    systime_core #(.REDUCED(1'b1)) u_dut_r (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata_r), .time_now(time_r));

    // model state, index 0 full variant, index 1 reduced variant
    logic [63:0] m_t   [2];
    logic [31:0] m_inc [2];
    logic [31:0] m_sh  [2];
    logic        m_held[2];

    // {wr, rd, addr[1:0], wdata[31:0]}
    localparam int NV = 24;
    localparam logic [35:0] VEC [NV] = '{
        {1'b1,1'b0,2'd2,32'h66666666}, // R5 program nominal increment
        {1'b0,1'b0,2'd0,32'h0},        // R2 first advance
        {1'b0,1'b1,2'd2,32'h0},        // R3 read increment
        {1'b0,1'b1,2'd0,32'h0},        // R6 capture
        {1'b0,1'b1,2'd1,32'h0},        // R6 release
        {1'b0,1'b1,2'd1,32'h0},        // R7 live high
        {1'b1,1'b0,2'd0,32'hFFFFFFF0}, // R4 low write, carry follows
        {1'b0,1'b0,2'd0,32'h0},        // R2 carry into high
        {1'b0,1'b1,2'd0,32'h0},        // R6
        {1'b1,1'b0,2'd2,32'hFFFFFFFF}, // R3 R5 masked increment
        {1'b0,1'b1,2'd2,32'h0},        // R3 readback width
        {1'b0,1'b0,2'd0,32'h0},
        {1'b0,1'b1,2'd0,32'h0},        // R6 capture
        {1'b1,1'b0,2'd1,32'hFFFFFFFF}, // R4 R8 high write while held
        {1'b0,1'b1,2'd1,32'h0},        // R8 live after discard
        {1'b0,1'b0,2'd0,32'h0},        // R2 wrap
        {1'b0,1'b0,2'd0,32'h0},
        {1'b0,1'b1,2'd0,32'h0},        // R6
        {1'b1,1'b0,2'd0,32'h12345678}, // R4 R8 low write while held
        {1'b0,1'b1,2'd1,32'h0},        // R8
        {1'b0,1'b1,2'd3,32'h0},        // R9 reserved
        {1'b1,1'b0,2'd2,32'h00000000}, // R5 stop the clock
        {1'b0,1'b0,2'd0,32'h0},        // R5 last old-step
        {1'b0,1'b1,2'd0,32'h0}         // R5 frozen
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int v = 0; v < 2; v++) begin
            m_t[v] = '0; m_inc[v] = '0; m_sh[v] = '0; m_held[v] = 1'b0;
        end
    endtask

    // one bus cycle: drive at negedge, check before the next posedge, advance model
    task automatic step(input logic wr, input logic rd, input logic [1:0] ad,
                        input logic [31:0] wd);
        logic [31:0] exp_rd;
        string tag;
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = ad; reg_wdata = wd;
        #1;
        for (int v = 0; v < 2; v++) begin
            exp_rd = 32'd0;
            tag = "R9";
            if (rd) begin
                case (ad)
                    2'd0: begin exp_rd = m_t[v][31:0]; tag = "R6"; end
                    2'd1: begin
                        exp_rd = m_held[v] ? m_sh[v] : m_t[v][63:32];
                        tag = m_held[v] ? "R6" : "R7";
                    end
                    2'd2: begin
                        exp_rd = (v == 0) ? m_inc[v] : (32'h01000000 | m_inc[v]);
                        tag = "R3";
                    end
                    default: begin exp_rd = 32'd0; tag = "R9"; end
                endcase
            end
            chk(tag, {32'd0, (v == 0) ? rdata_f : rdata_r}, {32'd0, exp_rd});
            chk("R10", (v == 0) ? time_f : time_r, m_t[v]);
        end
        for (int v = 0; v < 2; v++) begin
            if (rd && ad == 2'd0) begin
                m_sh[v] = m_t[v][63:32]; m_held[v] = 1'b1;
            end else if (rd && ad == 2'd1) m_held[v] = 1'b0;
            else if (wr && ad <= 2'd1)     m_held[v] = 1'b0;
            if (wr && ad == 2'd0)      m_t[v] = {m_t[v][63:32], wd};
            else if (wr && ad == 2'd1) m_t[v] = {wd, m_t[v][31:0]};
            else                       m_t[v] = m_t[v] + {32'd0, m_inc[v]};
            if (wr && ad == 2'd2)
                m_inc[v] = (v == 0) ? (wd & 32'h7FFFFFFF) : (wd & 32'h00FFFFFF);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        // R1 state while held in reset
        chk("R1", time_f, 64'd0);
        chk("R1", time_r, 64'd0);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        model_reset();
        do_reset();
        // R1 increment reads zero and time holds after reset
        step(1'b0, 1'b1, 2'd2, 32'd0);
        step(1'b0, 1'b1, 2'd1, 32'd0);
        step(1'b0, 1'b0, 2'd0, 32'd0);

        for (int i = 0; i < NV; i++)
            step(VEC[i][35], VEC[i][34], VEC[i][33:32], VEC[i][31:0]);

        // R2 long run at a fine increment
        step(1'b1, 1'b0, 2'd2, 32'h00ABCDEF);
        for (int i = 0; i < 40; i++) step(1'b0, 1'b0, 2'd0, 32'd0);
        step(1'b0, 1'b1, 2'd0, 32'd0);
        step(1'b0, 1'b1, 2'd1, 32'd0);

        // R1 reset mid-run clears everything and leaves RD_LIVE
        step(1'b0, 1'b1, 2'd0, 32'd0);
        do_reset();
        step(1'b0, 1'b1, 2'd1, 32'd0);
        step(1'b0, 1'b1, 2'd2, 32'd0);

        // R5 back-to-back increment writes
        step(1'b1, 1'b0, 2'd2, 32'h40000000);
        step(1'b1, 1'b0, 2'd2, 32'h50000000);
        step(1'b0, 1'b0, 2'd0, 32'd0);
        step(1'b0, 1'b1, 2'd0, 32'd0);
        step(1'b0, 1'b1, 2'd0, 32'd0);
        step(1'b0, 1'b1, 2'd1, 32'd0);

        @(negedge clk);
        reg_rd = 1'b0; reg_wr = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule